// File: doc/BRIEF.md
# Reorder Buffer with Throttled Squash

This block is the in-order instruction window of an out-of-order core. Dispatch appends entries at the tail, each holding a program counter, a next program counter and a sequence number. Execution marks entries complete through a per-slot ready strobe. Commit retires the oldest entry at the head once that entry is ready. Head and tail are wrap-around slot indices, and an occupancy counter runs beside them.

A squash request names a sequence number. The block does not reset its pointers in one cycle. It walks backward from the tail and handles at most `SQ_W` entries per cycle. Every entry younger than the named one is tagged squashed and ready, so these entries leave through the normal retirement path. The walk stops on the named entry. If that entry has already retired, the walk stops at the head instead.

A two-state machine controls the block. In `IDLE`, inserts and retires are served. The transition `START_WALK` (IDLE→WALK) is taken on a squash request while the buffer is not empty. In `WALK`, the walker runs while inserts and retires are held off. The transition `WALK_STEP` (WALK→WALK) is taken while the walk has not ended. The transition `WALK_END` (WALK→IDLE) is taken when the walk lands on the target or on the head.

Top module: `rob_window`

## Requirements
- R1: After reset the buffer is empty: occupancy 0, free count DEPTH, squash_done high, head_ready low.
- R2: An accepted insert writes the next slot in order, starting at slot 0 after reset and wrapping after slot DEPTH-1. Occupancy rises by one, tail_pc and tail_seq show the newest entry, and ins_slot shows the slot the next insert will use.
- R3: When occupancy equals DEPTH, an insert is refused: ins_accept stays low and occupancy and the tail fields do not change.
- R4: head_ready is low whenever the buffer is empty. Otherwise it equals the ready bit of the head entry. A new entry starts not ready, and a pulse on rdy_set makes slot rdy_idx ready.
- R5: retire_req removes the head entry only when head_ready is high: retire_fire goes high, occupancy falls by one, and the head fields move to the next entry. When head_ready is low, retire_req has no effect. free_cnt always equals DEPTH minus occupancy.
- R6: An insert and a retire in the same cycle leave occupancy unchanged, and both take effect.
- R7: A squash request on a non-empty buffer drops squash_done on the following edge. The walk then starts at the tail and moves toward the head, examining at most SQ_W entries per cycle. It ends when it reaches the entry whose sequence number equals squash_seq. That entry is not marked, and squash_done rises on the edge that ends the walk.
- R8: Every entry the walk passes is strictly younger than the target and becomes both squashed and ready. These entries retire through the normal head path with head_squashed high.
- R9: If the target is not in the buffer, the walk marks every entry down to and including the head, then ends with squash_done high.
- R10: A squash request on an empty buffer is ignored: squash_done stays high.
- R11: While squash_done is low, and in the cycle of any squash request, inserts and retires are ignored and occupancy holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_pc | input | PC_W | PC of the new entry |
| ins_npc | input | PC_W | Next PC of the new entry |
| ins_seq | input | SEQ_W | Sequence number of the new entry |
| ins_accept | output | 1 | Insert taken this cycle |
| ins_slot | output | IDX_W | Slot the next insert writes |
| rdy_set | input | 1 | Mark one slot ready to commit |
| rdy_idx | input | IDX_W | Slot to mark ready |
| retire_req | input | 1 | Commit asks to retire the head |
| retire_fire | output | 1 | Head retired this cycle |
| squash_req | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Target sequence number of the squash |
| squash_done | output | 1 | No squash walk in progress |
| occupancy | output | CNT_W | Entries held |
| free_cnt | output | CNT_W | Free entries |
| head_ready | output | 1 | Head entry may retire |
| head_pc | output | PC_W | Head entry PC |
| head_npc | output | PC_W | Head entry next PC |
| head_seq | output | SEQ_W | Head entry sequence number |
| head_squashed | output | 1 | Head entry was squashed |
| tail_pc | output | PC_W | Newest entry PC |
| tail_seq | output | SEQ_W | Newest entry sequence number |

## Verification
The hardest situation to reach is a walk that spans several cycles and has a known cycle-by-cycle end. The bench loads six entries and squashes to the second one. With SQ_W of 2, the walk needs exactly three edges after the request, and the bench samples squash_done between those edges. While the walk runs, the bench also pulses an insert and a retire to show both are ignored. A second case squashes to a sequence number that has already retired. Here the walk must end at the head and not wrap past it, which shows up as every remaining entry draining with head_squashed high.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_slots.sv
module rob_slots #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [PC_W-1:0]              wr_pc,
    input  logic [PC_W-1:0]              wr_npc,
    input  logic [SEQ_W-1:0]             wr_seq,
    input  logic                         rdy_en,
    input  logic [IDX_W-1:0]             rdy_idx,
    input  logic [DEPTH-1:0]             kill_mask,
    output logic [DEPTH-1:0][PC_W-1:0]   pc_arr,
    output logic [DEPTH-1:0][PC_W-1:0]   npc_arr,
    output logic [DEPTH-1:0][SEQ_W-1:0]  seq_arr,
    output logic [DEPTH-1:0]             rdy_arr,
    output logic [DEPTH-1:0]             kill_arr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_arr   <= '0;
            npc_arr  <= '0;
            seq_arr  <= '0;
            rdy_arr  <= '0;
            kill_arr <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (kill_mask[i]) begin
                    rdy_arr[i]  <= 1'b1;
                    kill_arr[i] <= 1'b1;
                end
            end
            if (rdy_en) begin
                rdy_arr[rdy_idx] <= 1'b1;
            end
            if (wr_en) begin
                pc_arr[wr_idx]   <= wr_pc;
                npc_arr[wr_idx]  <= wr_npc;
                seq_arr[wr_idx]  <= wr_seq;
                rdy_arr[wr_idx]  <= 1'b0;
                kill_arr[wr_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_walker.sv
module rob_walker #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    parameter int SQ_W  = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         active,
    input  logic [IDX_W-1:0]             start_ptr,
    input  logic [IDX_W-1:0]             head_idx,
    input  logic [SEQ_W-1:0]             target,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_arr,
    output logic [DEPTH-1:0]             kill_mask,
    output logic [IDX_W-1:0]             next_ptr,
    output logic                         finish
);
    logic [IDX_W-1:0] p;
    logic             stop;

    always_comb begin
        p         = start_ptr;
        stop      = 1'b0;
        kill_mask = '0;
        finish    = 1'b0;
        for (int k = 0; k < SQ_W; k++) begin
            if (active && !stop) begin
                if (seq_arr[p] == target) begin
                    stop   = 1'b1;
                    finish = 1'b1;
                end else begin
                    kill_mask[p] = 1'b1;
                    if (p == head_idx) begin
                        stop   = 1'b1;
                        finish = 1'b1;
                    end else begin
                        p = (p == '0) ? IDX_W'(DEPTH - 1) : p - 1'b1;
                    end
                end
            end
        end
        next_ptr = p;
    end
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic             retire_req,
    input  logic             head_rdy_bit,
    input  logic             squash_req,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic [IDX_W-1:0] walk_next,
    input  logic             walk_finish,
    output rob_state_e       state,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W-1:0] walk_ptr,
    output logic [SEQ_W-1:0] target,
    output logic [CNT_W-1:0] count,
    output logic             ins_fire,
    output logic             ret_fire,
    output logic             walking
);
    rob_state_e state_nx;
    logic       squash_go;
    logic       idle_free;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] x);
        return (x == IDX_W'(DEPTH - 1)) ? '0 : x + 1'b1;
    endfunction

    always_comb begin
        idle_free = (state == ST_IDLE) && !squash_req;
        squash_go = squash_req && (state == ST_IDLE) && (count != '0);
        ins_fire  = ins_valid && idle_free && (count < CNT_W'(DEPTH));
        ret_fire  = retire_req && idle_free && (count != '0) && head_rdy_bit;
        tail_idx  = (wr_idx == '0) ? IDX_W'(DEPTH - 1) : wr_idx - 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (squash_go)   state_nx = ST_WALK;
            ST_WALK: if (walk_finish) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        walking = (state == ST_WALK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_idx <= '0;
            wr_idx   <= '0;
            count    <= '0;
            walk_ptr <= '0;
            target   <= '0;
        end else begin
            if (ins_fire) wr_idx   <= bump(wr_idx);
            if (ret_fire) head_idx <= bump(head_idx);
            if (ins_fire && !ret_fire)      count <= count + 1'b1;
            else if (ret_fire && !ins_fire) count <= count - 1'b1;
            if (squash_go) begin
                walk_ptr <= tail_idx;
                target   <= squash_seq;
            end else if (state == ST_WALK) begin
                walk_ptr <= walk_next;
            end
        end
    end
endmodule

// File: rtl/rob_window.sv
module rob_window
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    parameter int SQ_W  = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             ins_accept,
    output logic [IDX_W-1:0] ins_slot,
    input  logic             rdy_set,
    input  logic [IDX_W-1:0] rdy_idx,
    input  logic             retire_req,
    output logic             retire_fire,
    input  logic             squash_req,
    input  logic [SEQ_W-1:0] squash_seq,
    output logic             squash_done,
    output logic [CNT_W-1:0] occupancy,
    output logic [CNT_W-1:0] free_cnt,
    output logic             head_ready,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic [SEQ_W-1:0] head_seq,
    output logic             head_squashed,
    output logic [PC_W-1:0]  tail_pc,
    output logic [SEQ_W-1:0] tail_seq
);
    rob_state_e                 state;
    logic [IDX_W-1:0]           head_idx, wr_idx, tail_idx, walk_ptr, walk_next;
    logic [SEQ_W-1:0]           target;
    logic [CNT_W-1:0]           count;
    logic                       ins_fire, ret_fire, walking, walk_finish;
    logic [DEPTH-1:0]           kill_mask;
    logic [DEPTH-1:0][PC_W-1:0] pc_arr, npc_arr;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_arr;
    logic [DEPTH-1:0]           rdy_arr, kill_arr;

    rob_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .retire_req(retire_req),
        .head_rdy_bit(rdy_arr[head_idx]),
        .squash_req(squash_req), .squash_seq(squash_seq),
        .walk_next(walk_next), .walk_finish(walk_finish),
        .state(state), .head_idx(head_idx), .wr_idx(wr_idx),
        .tail_idx(tail_idx), .walk_ptr(walk_ptr), .target(target),
        .count(count), .ins_fire(ins_fire), .ret_fire(ret_fire),
        .walking(walking)
    );

    rob_walker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) u_walk (
        .active(walking), .start_ptr(walk_ptr), .head_idx(head_idx),
        .target(target), .seq_arr(seq_arr),
        .kill_mask(kill_mask), .next_ptr(walk_next), .finish(walk_finish)
    );

    rob_slots #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ins_fire), .wr_idx(wr_idx),
        .wr_pc(ins_pc), .wr_npc(ins_npc), .wr_seq(ins_seq),
        .rdy_en(rdy_set), .rdy_idx(rdy_idx), .kill_mask(kill_mask),
        .pc_arr(pc_arr), .npc_arr(npc_arr), .seq_arr(seq_arr),
        .rdy_arr(rdy_arr), .kill_arr(kill_arr)
    );

    always_comb begin
        ins_accept    = ins_fire;
        ins_slot      = wr_idx;
        retire_fire   = ret_fire;
        squash_done   = !walking;
        occupancy     = count;
        free_cnt      = CNT_W'(DEPTH) - count;
        head_ready    = (count != '0) && rdy_arr[head_idx];
        head_pc       = pc_arr[head_idx];
        head_npc      = npc_arr[head_idx];
        head_seq      = seq_arr[head_idx];
        head_squashed = kill_arr[head_idx];
        tail_pc       = pc_arr[tail_idx];
        tail_seq      = seq_arr[tail_idx];
    end
endmodule

// File: rtl/rob_window_chk.sv
module rob_window_chk #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ins_accept,
    input logic                        squash_req,
    input logic                        squash_done,
    input logic [CNT_W-1:0]            occupancy,
    input logic                        head_ready,
    input logic [DEPTH-1:0]            kill_mask,
    input logic [DEPTH-1:0][SEQ_W-1:0] seq_arr,
    input logic [SEQ_W-1:0]            target
);
    logic past_ok;
    logic older_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_comb begin
        older_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (kill_mask[i] && !(seq_arr[i] > target)) older_hit = 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    assert_full_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CNT_W'(DEPTH)) |-> !ins_accept);

    assert_empty_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0) |-> !head_ready);

    assert_walk_holds_R11: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !squash_done |=> (occupancy == $past(occupancy)));

    assert_squash_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_req && squash_done && occupancy != '0) |=> !squash_done);

    assert_empty_squash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_req && squash_done && occupancy == '0) |=> squash_done);

    assert_only_younger_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !older_hit);
endmodule

bind rob_window rob_window_chk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ins_accept(ins_accept),
    .squash_req(squash_req), .squash_done(squash_done),
    .occupancy(occupancy), .head_ready(head_ready),
    .kill_mask(kill_mask), .seq_arr(seq_arr), .target(target)
);

// File: tb/rob_window_bench.sv
module rob_window_bench;
    localparam int DEPTH = 8;
    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;
    localparam int SQ_W  = 2;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ins_valid = 1'b0;
    logic [PC_W-1:0]  ins_pc = '0;
    logic [PC_W-1:0]  ins_npc = '0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic             ins_accept;
    logic [IDX_W-1:0] ins_slot;
    logic             rdy_set = 1'b0;
    logic [IDX_W-1:0] rdy_idx = '0;
    logic             retire_req = 1'b0;
    logic             retire_fire;
    logic             squash_req = 1'b0;
    logic [SEQ_W-1:0] squash_seq = '0;
    logic             squash_done;
    logic [CNT_W-1:0] occupancy, free_cnt;
    logic             head_ready, head_squashed;
    logic [PC_W-1:0]  head_pc, head_npc, tail_pc;
    logic [SEQ_W-1:0] head_seq, tail_seq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rob_window #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) u_rob_window (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_npc(ins_npc), .ins_seq(ins_seq),
        .ins_accept(ins_accept), .ins_slot(ins_slot),
        .rdy_set(rdy_set), .rdy_idx(rdy_idx),
        .retire_req(retire_req), .retire_fire(retire_fire),
        .squash_req(squash_req), .squash_seq(squash_seq), .squash_done(squash_done),
        .occupancy(occupancy), .free_cnt(free_cnt),
        .head_ready(head_ready), .head_pc(head_pc), .head_npc(head_npc),
        .head_seq(head_seq), .head_squashed(head_squashed),
        .tail_pc(tail_pc), .tail_seq(tail_seq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic push(input int seq);
        ins_valid = 1'b1;
        ins_seq   = SEQ_W'(seq);
        ins_pc    = PC_W'(32'h1000 + seq * 4);
        ins_npc   = PC_W'(32'h1000 + seq * 4 + 4);
        tick();
        ins_valid = 1'b0;
    endtask

    task automatic mark_ready(input int slot);
        rdy_set = 1'b1;
        rdy_idx = IDX_W'(slot);
        tick();
        rdy_set = 1'b0;
    endtask

    task automatic retire_one();
        retire_req = 1'b1;
        tick();
        retire_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 occupancy", occupancy, 0);
        check("R1 free", free_cnt, DEPTH);
        check("R1 done", squash_done, 1);
        check("R1 head_ready", head_ready, 0);
    endtask

    task automatic t_insert_retire();
        do_reset();
        push(10); push(11); push(12);
        check("R2 occupancy", occupancy, 3);
        check("R5 free", free_cnt, DEPTH - 3);
        check("R2 head_seq", head_seq, 10);
        check("R2 head_pc", head_pc, 32'h1000 + 40);
        check("R2 head_npc", head_npc, 32'h1000 + 44);
        check("R2 tail_seq", tail_seq, 12);
        check("R2 tail_pc", tail_pc, 32'h1000 + 48);
        check("R2 ins_slot", ins_slot, 3);
        check("R4 not ready yet", head_ready, 0);
        retire_req = 1'b1;
        #1;
        check("R5 no fire when not ready", retire_fire, 0);
        tick();
        retire_req = 1'b0;
        check("R5 retire ignored", occupancy, 3);
        mark_ready(0);
        check("R4 ready after set", head_ready, 1);
        retire_one();
        check("R5 occupancy after retire", occupancy, 2);
        check("R5 head advances", head_seq, 11);
        check("R5 free after retire", free_cnt, DEPTH - 2);
        mark_ready(1);
        ins_valid = 1'b1; ins_seq = 16'd13; ins_pc = 32'h1034; ins_npc = 32'h1038;
        retire_req = 1'b1;
        tick();
        ins_valid = 1'b0; retire_req = 1'b0;
        check("R6 occupancy held", occupancy, 2);
        check("R6 head moved", head_seq, 12);
        check("R6 tail moved", tail_seq, 13);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(40 + i);
        check("R3 full occupancy", occupancy, DEPTH);
        check("R3 free zero", free_cnt, 0);
        check("R2 slot wrapped", ins_slot, 0);
        ins_valid = 1'b1; ins_seq = 16'd99;
        #1;
        check("R3 accept low", ins_accept, 0);
        tick();
        ins_valid = 1'b0;
        check("R3 occupancy held", occupancy, DEPTH);
        check("R3 tail unchanged", tail_seq, 40 + DEPTH - 1);
    endtask

    task automatic t_squash_walk();
        do_reset();
        for (int i = 0; i < 6; i++) push(20 + i);
        squash_req = 1'b1; squash_seq = 16'd21;
        ins_valid = 1'b1; ins_seq = 16'd77;
        tick();
        squash_req = 1'b0;
        check("R11 insert with squash ignored", occupancy, 6);
        check("R7 done low after request", squash_done, 0);
        retire_req = 1'b1;
        tick();
        ins_valid = 1'b0; retire_req = 1'b0;
        check("R7 still walking after step 1", squash_done, 0);
        check("R11 occupancy held in walk", occupancy, 6);
        tick();
        check("R7 still walking after step 2", squash_done, 0);
        tick();
        check("R7 done after landing on target", squash_done, 1);
        check("R11 tail unchanged", tail_seq, 25);
        check("R7 head not marked", head_ready, 0);
        mark_ready(0);
        mark_ready(1);
        retire_one();
        check("R7 target unmarked", head_squashed, 0);
        check("R7 target seq", head_seq, 21);
        retire_one();
        check("R8 younger is ready", head_ready, 1);
        check("R8 younger is squashed", head_squashed, 1);
        check("R8 younger seq", head_seq, 22);
        for (int i = 0; i < 4; i++) retire_one();
        check("R8 all drained", occupancy, 0);
    endtask

    task automatic t_squash_past_head();
        do_reset();
        push(30); push(31); push(32);
        squash_req = 1'b1; squash_seq = 16'd29;
        tick();
        squash_req = 1'b0;
        tick();
        check("R9 walking after step 1", squash_done, 0);
        tick();
        check("R9 done at head", squash_done, 1);
        check("R9 head squashed", head_squashed, 1);
        check("R9 head ready", head_ready, 1);
        check("R9 occupancy", occupancy, 3);
    endtask

    task automatic t_squash_empty();
        do_reset();
        squash_req = 1'b1; squash_seq = 16'd5;
        tick();
        squash_req = 1'b0;
        check("R10 done stays high", squash_done, 1);
        tick();
        check("R10 still idle", squash_done, 1);
        check("R10 still empty", occupancy, 0);
    endtask

    initial begin
        t_reset();
        t_insert_retire();
        t_full();
        t_squash_walk();
        t_squash_past_head();
        t_squash_empty();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule